// File: doc/BRIEF.md
# Half-Precision Float Classifier

This block takes one 16-bit half-precision floating-point word and reports which of ten categories it falls into, as a one-hot mask. It separates positive from negative for infinities, normal numbers, subnormal numbers and zeros. It also separates the two kinds of NaN, and it does not look at the sign to do that. The block has no arithmetic, no rounding and no exception flags.

The word is split into a sign (bit 15), a 5-bit exponent (bits 14:10) and a 10-bit fraction (bits 9:0). An exponent of all ones means infinity or NaN. An exponent of all zeros means zero or subnormal. Any other exponent means a normal number.

By default the mask is registered behind a simple valid strobe. Setting `REG_OUT` to 0 gives the purely combinational variant, where `out_valid` is `in_valid` passed straight through.

Mask bit order, fixed:

| Bit | Class |
|-----|-------|
| 0 | negative infinity |
| 1 | negative normal |
| 2 | negative subnormal |
| 3 | negative zero |
| 4 | positive zero |
| 5 | positive subnormal |
| 6 | positive normal |
| 7 | positive infinity |
| 8 | signaling NaN |
| 9 | quiet NaN |

Top module: `hpc_classifier`

## Requirements
- R1: When the exponent is all ones and the fraction is zero, the mask is bit 0 if the sign is 1 and bit 7 if the sign is 0 (0x7C00 gives 10'h080).
- R2: When the exponent is neither all zeros nor all ones, the mask is bit 1 for a negative sign and bit 6 for a positive sign.
- R3: When the exponent is zero and the fraction is nonzero, the mask is bit 2 for a negative sign and bit 5 for a positive sign (0x0001 gives 10'h020).
- R4: When the exponent is zero and the fraction is zero, the mask is bit 3 for a negative sign and bit 4 for a positive sign (0x8000 gives 10'h008).
- R5: When the exponent is all ones and fraction bit 9 is 1, the mask is bit 9 whatever the sign (0x7E00 gives 10'h200).
- R6: When the exponent is all ones, fraction bit 9 is 0 and the fraction is nonzero, the mask is bit 8 whatever the sign (0x7D00 gives 10'h100).
- R7: For every one of the 65536 input encodings, exactly one mask bit is set.
- R8: With `REG_OUT`=1, an operand presented with `in_valid` high appears on `class_mask` with `out_valid` high one clock later. While `in_valid` is low, `out_valid` is low and `class_mask` keeps its last value.
- R9: While reset is asserted, and after it is released, `out_valid` is 0 and `class_mask` is 0 until the first valid operand is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; used only when the output is registered |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| operand | input | 16 | Half-precision word to classify |
| out_valid | output | 1 | Mask strobe |
| class_mask | output | 10 | One-hot class mask |

## Verification
The bench drives every one of the 65536 encodings, so each boundary is covered:
- **Exponent limits.** A decoder that mishandled the all-ones or all-zeros exponent would call an infinity or subnormal "normal".
- **Fraction bit 9.** A decoder that used the wrong fraction bit would swap the quiet and signaling NaN bits.
- **Sign on NaNs.** A decoder that let the sign reach the NaN decode would raise a signed class for a negative NaN, or set two bits at once.
- **Idle gaps.** Gaps in the strobe show whether the mask holds its value or drifts while no operand is offered.
- **Reset state.** The state right after reset is checked for a stale mask or a spurious valid.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
    localparam int EXP_W   = 5;
    localparam int FRAC_W  = 10;
    localparam int CLASS_N = 10;

    typedef enum int unsigned {
        CL_NEG_INF  = 0,
        CL_NEG_NORM = 1,
        CL_NEG_SUB  = 2,
        CL_NEG_ZERO = 3,
        CL_POS_ZERO = 4,
        CL_POS_SUB  = 5,
        CL_POS_NORM = 6,
        CL_POS_INF  = 7,
        CL_SNAN     = 8,
        CL_QNAN     = 9
    } class_idx_e;

    typedef struct packed {
        logic sign;
        logic exp_max;
        logic exp_min;
        logic frac_nz;
        logic quiet_bit;
    } fields_t;
endpackage

// File: rtl/hpc_field_split.sv
module hpc_field_split
    import hpc_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW:0] word,
    output fields_t        fields
);
    localparam int SIGN_POS = EW + FW;

    logic [EW-1:0] exp_f;
    logic [FW-1:0] frac_f;

    assign exp_f  = word[SIGN_POS-1 -: EW];
    assign frac_f = word[FW-1:0];

    always_comb begin
        fields.sign      = word[SIGN_POS];
        fields.exp_max   = &exp_f;
        fields.exp_min   = ~|exp_f;
        fields.frac_nz   = |frac_f;
        fields.quiet_bit = frac_f[FW-1];
    end
endmodule

// File: rtl/hpc_class_encode.sv
module hpc_class_encode
    import hpc_pkg::*;
(
    input  fields_t              fields,
    output logic [CLASS_N-1:0]   mask
);
    always_comb begin
        mask = '0;
        if (fields.exp_max) begin
            if (!fields.frac_nz) begin
                if (fields.sign) mask[CL_NEG_INF] = 1'b1;
                else             mask[CL_POS_INF] = 1'b1;
            end else if (fields.quiet_bit) begin
                mask[CL_QNAN] = 1'b1;
            end else begin
                mask[CL_SNAN] = 1'b1;
            end
        end else if (fields.exp_min) begin
            if (fields.frac_nz) begin
                if (fields.sign) mask[CL_NEG_SUB] = 1'b1;
                else             mask[CL_POS_SUB] = 1'b1;
            end else begin
                if (fields.sign) mask[CL_NEG_ZERO] = 1'b1;
                else             mask[CL_POS_ZERO] = 1'b1;
            end
        end else begin
            if (fields.sign) mask[CL_NEG_NORM] = 1'b1;
            else             mask[CL_POS_NORM] = 1'b1;
        end
    end
endmodule

// File: rtl/hpc_classifier.sv
module hpc_classifier
    import hpc_pkg::*;
#(
    parameter int EW      = EXP_W,
    parameter int FW      = FRAC_W,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [EW+FW:0]     operand,
    output logic               out_valid,
    output logic [CLASS_N-1:0] class_mask
);
    localparam int SIGN_POS = EW + FW;

    fields_t              fields;
    logic [CLASS_N-1:0]   mask_comb;

    hpc_field_split #(.EW(EW), .FW(FW)) u_split (
        .word   (operand),
        .fields (fields)
    );

    hpc_class_encode u_encode (
        .fields (fields),
        .mask   (mask_comb)
    );

    generate
        if (REG_OUT) begin : g_reg
            logic               valid_q;
            logic [CLASS_N-1:0] mask_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q <= 1'b0;
                    mask_q  <= '0;
                end else begin
                    valid_q <= in_valid;
                    if (in_valid) mask_q <= mask_comb;
                end
            end

            assign out_valid  = valid_q;
            assign class_mask = mask_q;

            p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> (!out_valid && $stable(class_mask)));
            p_one_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> ($countones(class_mask) == 1));
            p_nan_unsigned_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (&operand[SIGN_POS-1 -: EW]) && operand[FW-1])
                |=> class_mask[CL_QNAN]);
            p_snan_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (&operand[SIGN_POS-1 -: EW]) && !operand[FW-1]
                 && (|operand[FW-1:0])) |=> class_mask[CL_SNAN]);
            p_inf_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (&operand[SIGN_POS-1 -: EW]) && !(|operand[FW-1:0]))
                |=> (class_mask[CL_NEG_INF] || class_mask[CL_POS_INF]));
        end else begin : g_comb
            assign out_valid  = in_valid;
            assign class_mask = mask_comb;
        end
    endgenerate
endmodule

// File: tb/hpc_classifier_tb.sv
module hpc_classifier_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] operand = '0;
    logic        out_valid;
    logic [9:0]  class_mask;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct { logic [15:0] op; logic [9:0] exp; } item_t;
    item_t sb_q[$];
    logic [9:0] last_mask = '0;

    always #2.5 clk = ~clk;

    hpc_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .out_valid(out_valid), .class_mask(class_mask)
    );

    function automatic logic [9:0] ref_class(input logic [15:0] w);
        logic       s;
        logic [4:0] e;
        logic [9:0] f;
        logic [9:0] r;
        s = w[15]; e = w[14:10]; f = w[9:0]; r = '0;
        if (e == 5'h1F && f == 0)      r[s ? 0 : 7] = 1'b1;
        else if (e == 5'h1F && f[9])   r[9] = 1'b1;
        else if (e == 5'h1F)           r[8] = 1'b1;
        else if (e == 0 && f != 0)     r[s ? 2 : 5] = 1'b1;
        else if (e == 0)               r[s ? 3 : 4] = 1'b1;
        else                           r[s ? 1 : 6] = 1'b1;
        return r;
    endfunction

    function automatic string req_of(input logic [9:0] m);
        if (m[0] || m[7]) return "R1";
        if (m[1] || m[6]) return "R2";
        if (m[2] || m[5]) return "R3";
        if (m[3] || m[4]) return "R4";
        if (m[9])         return "R5";
        return "R6";
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] op,
                         input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s op=%h actual=%h expected=%h", req, op, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] op, input logic [9:0] exp);
        @(negedge clk);
        operand  = op;
        in_valid = 1'b1;
        sb_q.push_back('{op, exp});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            operand  = 16'hFFFF;
        end
    endtask

    // Monitor: pops the scoreboard on each result, checks holds while idle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8", 16'h0, class_mask, 10'h0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(class_mask == it.exp, req_of(it.exp), it.op, class_mask, it.exp);
                    check($countones(class_mask) == 1, "R7", it.op, class_mask, it.exp);
                end
                last_mask = class_mask;
            end else begin
                check(class_mask == last_mask, "R8", operand, class_mask, last_mask);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && class_mask == 10'h0, "R9 in reset",
              16'h0, class_mask, 10'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && class_mask == 10'h0, "R9 after reset",
              16'h0, class_mask, 10'h0);
        // Directed vectors with literal expectations
        drive(16'h7C00, 10'h080);   // R1 +inf
        drive(16'hFC00, 10'h001);   // R1 -inf
        drive(16'h8000, 10'h008);   // R4 -zero
        drive(16'h0000, 10'h010);   // R4 +zero
        drive(16'h0001, 10'h020);   // R3 +sub
        drive(16'h83FF, 10'h004);   // R3 -sub
        drive(16'h3C00, 10'h040);   // R2 +norm
        drive(16'hFBFF, 10'h002);   // R2 -norm
        drive(16'h7E00, 10'h200);   // R5 qnan
        drive(16'hFE01, 10'h200);   // R5 negative qnan
        drive(16'h7D00, 10'h100);   // R6 snan
        drive(16'hFC01, 10'h100);   // R6 negative snan
        idle(3);                    // R8 hold
        // Exhaustive sweep (R7), with idle gaps to exercise hold (R8)
        for (int v = 0; v < 65536; v++) begin
            drive(v[15:0], ref_class(v[15:0]));
            if ((v % 4096) == 4095) idle(2);
        end
        idle(3);
        check(sb_q.size() == 0, "R8 drained", 16'h0, 10'(sb_q.size()), 10'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule